// File: doc/BRIEF.md
# Direct-Drive TFT Panel Timing Generator

This block produces every timing signal a directly driven 320x240 TFT panel needs, counting pixel clocks across a line and lines down a frame. A horizontal counter runs at the pixel clock and a vertical counter advances once per line. Decoders compare the counters against positions derived from a set of configuration fields. They drive a line pulse, a frame pulse, a shift-clock enable, a display-enable window and four panel control strobes placed at fixed pixel offsets around the line pulse.

The configuration fields arrive as plain parallel inputs. They are captured into shadow registers while reset is held and again on the last pixel of every frame, so a change made partway through a frame never tears the current frame. Pixel fetch and formatting live elsewhere. A downstream stage launches each 18-bit pixel on the falling edge of the shift clock while `disp_en` is high, which puts the data half a pixel clock ahead of the rising edge that samples it. No stream leaves this block, so it has no valid/ready interface and no back-pressure. Every pin is a plain control or timing signal, sampled or driven on `clk`.

Top module: `tft_direct_timing`

## Requirements
- R1: The horizontal counter counts 0 to HT-1 and wraps, where HT = (cfg_htotal + 1) * 8 pixel clocks; strobe_a therefore recurs every HT cycles within a frame.
- R2: The vertical counter advances on the last pixel of each line and wraps after VT = cfg_vtotal + 1 lines, so a frame lasts HT * VT cycles and frame_pulse rises once at its first pixel.
- R3: line_pulse is high while the horizontal count h satisfies LS <= h < LS + cfg_lwidth + 1, with LS = cfg_lstart + 1.
- R4: shift_en is high while DS <= h < DS + (cfg_hdisp + 1) * 8, with DS = cfg_hstart + 5; disp_en is shift_en further limited to lines v with cfg_vstart <= v < cfg_vstart + cfg_vdisp + 1.
- R5: frame_pulse is high for whole lines v < cfg_fwidth + 1.
- R6: strobe_a is high for exactly one cycle, at h = (LS + 59) mod HT.
- R7: strobe_b is high for 353 cycles starting at h = (LS - 5) mod HT, wrapping across the line end; strobe_c is always its complement.
- R8: strobe_d is 0 after reset and inverts once per line, becoming visible in the cycle after h = (LS - 11) mod HT.
- R9: Configuration inputs changed during a frame have no effect on any output until the first pixel of the next frame.
- R10: In the first cycle after reset both counters are 0, and the outputs are those that R3 to R8 give for h = 0 and v = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Synchronous active-low reset; loads the configuration |
| cfg_htotal | input | 7 | Line total in units of 8 pixels, minus one |
| cfg_hdisp | input | 7 | Display width in units of 8 pixels, minus one |
| cfg_lstart | input | 8 | Line pulse start position minus one |
| cfg_lwidth | input | 7 | Line pulse width minus one |
| cfg_hstart | input | 8 | Display start position minus five |
| cfg_vtotal | input | 10 | Frame total in lines, minus one |
| cfg_vstart | input | 10 | First displayed line |
| cfg_vdisp | input | 10 | Displayed line count minus one |
| cfg_fwidth | input | 4 | Frame pulse width in lines, minus one |
| line_pulse | output | 1 | Horizontal sync pulse |
| frame_pulse | output | 1 | Vertical sync pulse |
| shift_en | output | 1 | Shift-clock enable for the horizontal display window |
| disp_en | output | 1 | Pixel data valid window |
| strobe_a | output | 1 | One-pixel strobe after the line pulse |
| strobe_b | output | 1 | Long strobe that starts before the line pulse |
| strobe_c | output | 1 | Complement of strobe_b |
| strobe_d | output | 1 | Per-line toggle ahead of the line pulse |

## Verification
The assertions assume a configuration that fits inside one line. The line pulse ends before HT. The display window ends before HT. LS + 59 lies below 2 * HT, so one subtraction wraps every strobe position, and strobe_a never lands on the last pixel of a line. The stimulus uses two such settings, 440 and 400 pixels per line. The second places the line pulse at pixel 4, so strobe_b and strobe_d wrap into the previous line. The configuration is held steady while reset is asserted, and it changes only at a falling clock edge partway through a frame.

// File: rtl/tftg_pkg.sv
package tftg_pkg;
  localparam int TG_HW = 12;
  localparam int TG_VW = 12;

  typedef struct packed {
    logic [TG_HW-1:0] ht;
    logic [TG_HW-1:0] ht_last;
    logic [TG_HW-1:0] ls;
    logic [TG_HW-1:0] le;
    logic [TG_HW-1:0] ds;
    logic [TG_HW-1:0] dend;
    logic [TG_HW-1:0] sa;
    logic [TG_HW-1:0] sb;
    logic [TG_HW-1:0] sd;
    logic [TG_VW-1:0] vt_last;
    logic [TG_VW-1:0] vs;
    logic [TG_VW-1:0] ve;
    logic [TG_VW-1:0] fend;
  } timing_t;
endpackage

// File: rtl/tftg_cfg_calc.sv
module tftg_cfg_calc
  import tftg_pkg::*;
#(
  parameter int HT_FW   = 7,
  parameter int HD_FW   = 7,
  parameter int LS_FW   = 8,
  parameter int LW_FW   = 7,
  parameter int HS_FW   = 8,
  parameter int V_FW    = 10,
  parameter int FW_FW   = 4,
  parameter int SA_OFF  = 59,
  parameter int SB_LEAD = 5,
  parameter int SD_LEAD = 11,
  parameter int DS_ADD  = 5
) (
  input  logic [HT_FW-1:0] cfg_htotal,
  input  logic [HD_FW-1:0] cfg_hdisp,
  input  logic [LS_FW-1:0] cfg_lstart,
  input  logic [LW_FW-1:0] cfg_lwidth,
  input  logic [HS_FW-1:0] cfg_hstart,
  input  logic [V_FW-1:0]  cfg_vtotal,
  input  logic [V_FW-1:0]  cfg_vstart,
  input  logic [V_FW-1:0]  cfg_vdisp,
  input  logic [FW_FW-1:0] cfg_fwidth,
  output timing_t          t_o
);
  localparam logic [TG_HW-1:0] ONE_H = TG_HW'(1);
  localparam logic [TG_VW-1:0] ONE_V = TG_VW'(1);

  logic [TG_HW-1:0] ht, ls, sa_raw, sb_raw, sd_raw;

  // positions are first formed in [0, 2*HT) and wrapped with one subtraction
  always_comb begin
    ht     = (TG_HW'(cfg_htotal) + ONE_H) << 3;
    ls     = TG_HW'(cfg_lstart) + ONE_H;
    sa_raw = ls + TG_HW'(SA_OFF);
    sb_raw = ls + ht - TG_HW'(SB_LEAD);
    sd_raw = ls + ht - TG_HW'(SD_LEAD);

    t_o.ht      = ht;
    t_o.ht_last = ht - ONE_H;
    t_o.ls      = ls;
    t_o.le      = ls + TG_HW'(cfg_lwidth) + ONE_H;
    t_o.ds      = TG_HW'(cfg_hstart) + TG_HW'(DS_ADD);
    t_o.dend    = t_o.ds + ((TG_HW'(cfg_hdisp) + ONE_H) << 3);
    t_o.sa      = (sa_raw >= ht) ? sa_raw - ht : sa_raw;
    t_o.sb      = (sb_raw >= ht) ? sb_raw - ht : sb_raw;
    t_o.sd      = (sd_raw >= ht) ? sd_raw - ht : sd_raw;
    t_o.vt_last = TG_VW'(cfg_vtotal);
    t_o.vs      = TG_VW'(cfg_vstart);
    t_o.ve      = TG_VW'(cfg_vstart) + TG_VW'(cfg_vdisp) + ONE_V;
    t_o.fend    = TG_VW'(cfg_fwidth) + ONE_V;
  end
endmodule

// File: rtl/tftg_shadow.sv
module tftg_shadow
  import tftg_pkg::*;
(
  input  logic    clk,
  input  logic    load_i,
  input  timing_t next_i,
  output timing_t cur_o
);
  // captured during reset and on the last pixel of each frame only
  always_ff @(posedge clk) begin
    if (load_i) cur_o <= next_i;
  end
endmodule

// File: rtl/tftg_counters.sv
module tftg_counters #(
  parameter int HW = 12,
  parameter int VW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [HW-1:0] ht_last,
  input  logic [VW-1:0] vt_last,
  output logic [HW-1:0] hcnt,
  output logic [VW-1:0] vcnt,
  output logic          frame_end
);
  logic line_end;

  assign line_end  = (hcnt == ht_last);
  assign frame_end = line_end && (vcnt == vt_last);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hcnt <= '0;
      vcnt <= '0;
    end else if (line_end) begin
      hcnt <= '0;
      vcnt <= frame_end ? '0 : vcnt + VW'(1);
    end else begin
      hcnt <= hcnt + HW'(1);
    end
  end

  // R1: the last pixel of a line is followed by pixel 0
  a_r1_hwrap: assert property (@(posedge clk) disable iff (!rst_n)
    (hcnt == ht_last) |=> (hcnt == '0));

  // R2: the line count holds everywhere except at a line end
  a_r2_vhold: assert property (@(posedge clk) disable iff (!rst_n)
    (hcnt != ht_last) |=> $stable(vcnt));
endmodule

// File: rtl/tftg_strobes.sv
module tftg_strobes
  import tftg_pkg::*;
#(
  parameter int SB_W = 353
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [TG_HW-1:0] hcnt,
  input  logic [TG_VW-1:0] vcnt,
  input  timing_t          t,
  output logic             line_pulse,
  output logic             frame_pulse,
  output logic             shift_en,
  output logic             disp_en,
  output logic             strobe_a,
  output logic             strobe_b,
  output logic             strobe_c,
  output logic             strobe_d
);
  logic             vwin;
  logic [TG_HW-1:0] b_dist;

  always_comb begin
    line_pulse  = (hcnt >= t.ls) && (hcnt < t.le);
    shift_en    = (hcnt >= t.ds) && (hcnt < t.dend);
    vwin        = (vcnt >= t.vs) && (vcnt < t.ve);
    disp_en     = shift_en && vwin;
    frame_pulse = (vcnt < t.fend);
    strobe_a    = (hcnt == t.sa);
    // distance from the strobe_b start, taken modulo the line total
    b_dist      = (hcnt >= t.sb) ? hcnt - t.sb : hcnt + t.ht - t.sb;
    strobe_b    = (b_dist < TG_HW'(SB_W));
    strobe_c    = !strobe_b;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) strobe_d <= 1'b0;
    else if (hcnt == t.sd) strobe_d <= !strobe_d;
  end

  // R3: the line pulse begins exactly at its programmed position
  a_r3_rise_at_start: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(line_pulse) |-> (hcnt == t.ls));

  // R6: strobe_a never lasts two cycles
  a_r6_single: assert property (@(posedge clk) disable iff (!rst_n)
    strobe_a |=> !strobe_a);

  // R8: strobe_d only changes after its decode position was reached
  a_r8_dtoggle: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(strobe_d) |-> ($past(hcnt) == $past(t.sd)));

  // R4: pixel data is never valid outside the shift window
  a_r4_de_in_window: assert property (@(posedge clk) disable iff (!rst_n)
    disp_en |-> (hcnt >= t.ds) && (hcnt < t.dend));
endmodule

// File: rtl/tft_direct_timing.sv
module tft_direct_timing
  import tftg_pkg::*;
#(
  parameter int HT_FW   = 7,
  parameter int HD_FW   = 7,
  parameter int LS_FW   = 8,
  parameter int LW_FW   = 7,
  parameter int HS_FW   = 8,
  parameter int V_FW    = 10,
  parameter int FW_FW   = 4,
  parameter int SA_OFF  = 59,
  parameter int SB_LEAD = 5,
  parameter int SB_W    = 353,
  parameter int SD_LEAD = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [HT_FW-1:0] cfg_htotal,
  input  logic [HD_FW-1:0] cfg_hdisp,
  input  logic [LS_FW-1:0] cfg_lstart,
  input  logic [LW_FW-1:0] cfg_lwidth,
  input  logic [HS_FW-1:0] cfg_hstart,
  input  logic [V_FW-1:0]  cfg_vtotal,
  input  logic [V_FW-1:0]  cfg_vstart,
  input  logic [V_FW-1:0]  cfg_vdisp,
  input  logic [FW_FW-1:0] cfg_fwidth,
  output logic             line_pulse,
  output logic             frame_pulse,
  output logic             shift_en,
  output logic             disp_en,
  output logic             strobe_a,
  output logic             strobe_b,
  output logic             strobe_c,
  output logic             strobe_d
);
  timing_t          t_next, t_cur;
  logic [TG_HW-1:0] hcnt;
  logic [TG_VW-1:0] vcnt;
  logic             frame_end;
  logic             load;

  assign load = !rst_n || frame_end;

  tftg_cfg_calc #(
    .HT_FW(HT_FW), .HD_FW(HD_FW), .LS_FW(LS_FW), .LW_FW(LW_FW),
    .HS_FW(HS_FW), .V_FW(V_FW), .FW_FW(FW_FW),
    .SA_OFF(SA_OFF), .SB_LEAD(SB_LEAD), .SD_LEAD(SD_LEAD), .DS_ADD(5)
  ) u_calc (
    .cfg_htotal(cfg_htotal), .cfg_hdisp(cfg_hdisp), .cfg_lstart(cfg_lstart),
    .cfg_lwidth(cfg_lwidth), .cfg_hstart(cfg_hstart), .cfg_vtotal(cfg_vtotal),
    .cfg_vstart(cfg_vstart), .cfg_vdisp(cfg_vdisp), .cfg_fwidth(cfg_fwidth),
    .t_o(t_next)
  );

  tftg_shadow u_shadow (
    .clk(clk), .load_i(load), .next_i(t_next), .cur_o(t_cur)
  );

  tftg_counters #(.HW(TG_HW), .VW(TG_VW)) u_cnt (
    .clk(clk), .rst_n(rst_n), .ht_last(t_cur.ht_last), .vt_last(t_cur.vt_last),
    .hcnt(hcnt), .vcnt(vcnt), .frame_end(frame_end)
  );

  tftg_strobes #(.SB_W(SB_W)) u_strb (
    .clk(clk), .rst_n(rst_n), .hcnt(hcnt), .vcnt(vcnt), .t(t_cur),
    .line_pulse(line_pulse), .frame_pulse(frame_pulse), .shift_en(shift_en),
    .disp_en(disp_en), .strobe_a(strobe_a), .strobe_b(strobe_b),
    .strobe_c(strobe_c), .strobe_d(strobe_d)
  );

  // R9: timing positions move only on the cycle after a frame end
  a_r9_frame_only: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(frame_end) |-> $stable(t_cur.ht_last) && $stable(t_cur.ls));
endmodule

// File: tb/tft_direct_timing_test.sv
module tft_direct_timing_test;
  localparam int CLK_PERIOD = 10;
  localparam int RUN_CYCLES = 11800;
  localparam int CHG_CYCLE  = 2000;
  localparam int WATCHDOG   = 200000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [6:0] cfg_htotal, cfg_hdisp, cfg_lwidth;
  logic [7:0] cfg_lstart, cfg_hstart;
  logic [9:0] cfg_vtotal, cfg_vstart, cfg_vdisp;
  logic [3:0] cfg_fwidth;
  logic line_pulse, frame_pulse, shift_en, disp_en;
  logic strobe_a, strobe_b, strobe_c, strobe_d;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = !clk;

  tft_direct_timing uut (
    .clk(clk), .rst_n(rst_n),
    .cfg_htotal(cfg_htotal), .cfg_hdisp(cfg_hdisp), .cfg_lstart(cfg_lstart),
    .cfg_lwidth(cfg_lwidth), .cfg_hstart(cfg_hstart), .cfg_vtotal(cfg_vtotal),
    .cfg_vstart(cfg_vstart), .cfg_vdisp(cfg_vdisp), .cfg_fwidth(cfg_fwidth),
    .line_pulse(line_pulse), .frame_pulse(frame_pulse), .shift_en(shift_en),
    .disp_en(disp_en), .strobe_a(strobe_a), .strobe_b(strobe_b),
    .strobe_c(strobe_c), .strobe_d(strobe_d)
  );

  // model configuration, in requirement terms
  int m_ht, m_ls, m_le, m_ds, m_dend, m_sa, m_sb, m_sd, m_vt, m_vs, m_ve, m_fe;
  int hc, vc;
  bit dstate;
  logic [7:0] exp_q[$];

  task automatic set_cfg_a();
    cfg_htotal = 7'd54; cfg_hdisp = 7'd39; cfg_lstart = 8'd13; cfg_lwidth = 7'd0;
    cfg_hstart = 8'd69; cfg_vtotal = 10'd11; cfg_vstart = 10'd4; cfg_vdisp = 10'd5;
    cfg_fwidth = 4'd1;
  endtask

  task automatic set_cfg_b();
    cfg_htotal = 7'd49; cfg_hdisp = 7'd39; cfg_lstart = 8'd3; cfg_lwidth = 7'd2;
    cfg_hstart = 8'd20; cfg_vtotal = 10'd7; cfg_vstart = 10'd2; cfg_vdisp = 10'd2;
    cfg_fwidth = 4'd0;
  endtask

  task automatic model_load();
    m_ht   = (int'(cfg_htotal) + 1) * 8;
    m_ls   = int'(cfg_lstart) + 1;
    m_le   = m_ls + int'(cfg_lwidth) + 1;
    m_ds   = int'(cfg_hstart) + 5;
    m_dend = m_ds + (int'(cfg_hdisp) + 1) * 8;
    m_sa   = (m_ls + 59) % m_ht;
    m_sb   = (m_ls - 5 + m_ht) % m_ht;
    m_sd   = (m_ls - 11 + m_ht) % m_ht;
    m_vt   = int'(cfg_vtotal) + 1;
    m_vs   = int'(cfg_vstart);
    m_ve   = m_vs + int'(cfg_vdisp) + 1;
    m_fe   = int'(cfg_fwidth) + 1;
  endtask

  // driver side: expected outputs for the current model position
  task automatic drive_expect();
    logic [7:0] e;
    int bd;
    bd = (hc - m_sb + m_ht) % m_ht;
    e[0] = (hc >= m_ls) && (hc < m_le);
    e[1] = (vc < m_fe);
    e[2] = (hc >= m_ds) && (hc < m_dend);
    e[3] = e[2] && (vc >= m_vs) && (vc < m_ve);
    e[4] = (hc == m_sa);
    e[5] = (bd < 353);
    e[6] = !e[5];
    e[7] = dstate;
    exp_q.push_back(e);
  endtask

  task automatic check_bit(input string req, input string nm, input logic act, input logic ex, input int cyc);
    total++;
    if (act !== ex) begin
      bad++;
      $display("FAIL %s %s cycle=%0d h=%0d v=%0d actual=%b expected=%b", req, nm, cyc, hc, vc, act, ex);
    end
  endtask

  // monitor side: pop and compare against the ports
  task automatic monitor_check(input int cyc, input bit in_window);
    logic [7:0] e;
    string r9;
    e = exp_q.pop_front();
    r9 = in_window ? "R9 " : "";
    if (cyc == 0) begin
      check_bit("R10", "line_pulse", line_pulse, e[0], cyc);
      check_bit("R10", "strobe_c", strobe_c, e[6], cyc);
      check_bit("R10", "strobe_d", strobe_d, 1'b0, cyc);
    end
    check_bit({r9, "R3"}, "line_pulse",  line_pulse,  e[0], cyc);
    check_bit({r9, "R5"}, "frame_pulse", frame_pulse, e[1], cyc);
    check_bit({r9, "R4"}, "shift_en",    shift_en,    e[2], cyc);
    check_bit({r9, "R4"}, "disp_en",     disp_en,     e[3], cyc);
    check_bit({r9, "R6"}, "strobe_a",    strobe_a,    e[4], cyc);
    check_bit({r9, "R7"}, "strobe_b",    strobe_b,    e[5], cyc);
    check_bit({r9, "R7"}, "strobe_c",    strobe_c,    e[6], cyc);
    check_bit({r9, "R8"}, "strobe_d",    strobe_d,    e[7], cyc);
  endtask

  task automatic check_int(input string req, input int act, input int ex);
    total++;
    if (act != ex) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, ex);
    end
  endtask

  initial begin
    int last_fp, exp_len, last_a, frame_id, a_frame;
    logic prev_fp, prev_a;
    bit in_window;
    set_cfg_a();
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    model_load();
    hc = 0; vc = 0; dstate = 0;
    last_fp = 0; exp_len = m_ht * m_vt; last_a = -1; a_frame = -1; frame_id = 0;
    prev_fp = 1'b1; prev_a = 1'b0; in_window = 0;
    for (int cyc = 0; cyc < RUN_CYCLES; cyc++) begin
      drive_expect();
      monitor_check(cyc, in_window);
      // R2: frame length measured between frame pulse rises
      if (frame_pulse && !prev_fp) begin
        check_int("R2 frame length", cyc - last_fp, exp_len);
        last_fp = cyc;
        exp_len = m_ht * m_vt;
        frame_id++;
      end
      // R1: strobe_a period equals the line total within one frame
      if (strobe_a && !prev_a) begin
        if (a_frame == frame_id) check_int("R1 line period", cyc - last_a, m_ht);
        last_a = cyc;
        a_frame = frame_id;
      end
      prev_fp = frame_pulse;
      prev_a = strobe_a;
      if (cyc == CHG_CYCLE) begin
        set_cfg_b();
        in_window = 1;
      end
      // advance the model by one pixel clock
      if (hc == m_sd) dstate = !dstate;
      if (hc == m_ht - 1) begin
        hc = 0;
        if (vc == m_vt - 1) begin
          vc = 0;
          model_load();
          in_window = 0;
        end else begin
          vc++;
        end
      end else begin
        hc++;
      end
      @(negedge clk);
    end
    check_int("R2 frames seen", frame_id, 3);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule